// File: doc/BRIEF.md
# Half-Bridge Interlock Dead-Time Generator

This block sits between two already-filtered switching commands for the high-side and low-side switches of a half-bridge and the two gate-enable signals that drive them. In interlock mode it guarantees that the two enables are never asserted together. It also makes sure that a switch is enabled only after its partner's enable has been deasserted for at least a minimum gap. The gap is given in nanoseconds and turned into clock cycles from a clock-frequency parameter. Commands that already leave a large enough gap pass through with no added delay. Turn-off commands always reach the gate enable in the same cycle.

A static configuration input selects bypass. In bypass the block inserts no gap and applies no interlock: each enable follows its own command directly. Each direction has a saturating counter. The counter tracks how long the opposite enable has been off, so the gap is measured from the moment the partner switch actually stopped being driven. It is not measured from the moment its command fell.

Top module: `hb_deadtime_gen`

## Requirements
- R1: While `rst` is high both gate outputs are 0. On the first cycle after reset a lone command is passed at once, because both gap counters start out expired.
- R2: With `cfg_bypass` = 0, `gate_top` and `gate_bot` are never 1 in the same cycle.
- R3: With `cfg_bypass` = 0, if `cmd_top` and `cmd_bot` are both 1, both gate outputs are 0 until one command returns to 0.
- R4: A gate output is 0 in the same cycle in which its command is 0, in both modes.
- R5: With `cfg_bypass` = 0, a gate output may go to 1 only once the opposite gate output has been 0 for at least DEAD_CYC consecutive cycles. With a steady request, the first cycle with the output at 1 is exactly DEAD_CYC cycles after the first cycle in which the opposite output was 0.
- R6: With `cfg_bypass` = 0, when a command rises after the opposite output has already been 0 for DEAD_CYC cycles or more, the gate output follows the command in the same cycle.
- R7: A turn-on request that arrives during the gap is held off until the gap ends. If the command falls before that, the output never goes to 1.
- R8: The gap is counted from the cycle in which the opposite gate output went to 0, not from the cycle in which the opposite command went to 0.
- R9: With `cfg_bypass` = 1, `gate_top` equals `cmd_top` and `gate_bot` equals `cmd_bot` in every cycle, including when both commands are 1.
- R10: DEAD_CYC is the value of CLK_FREQ_HZ × DEAD_NS / 10^9 rounded up, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bypass | input | 1 | Static mode: 0 = interlock with gap, 1 = no gap and no interlock |
| cmd_top | input | 1 | Filtered switching command, high-side switch |
| cmd_bot | input | 1 | Filtered switching command, low-side switch |
| gate_top | output | 1 | Gate enable, high-side switch |
| gate_bot | output | 1 | Gate enable, low-side switch |

## Verification
The bench builds the block with CLK_FREQ_HZ = 125000000 and DEAD_NS = 80, which gives a gap of 10 cycles. At that size the last blocked cycle and the first permitted cycle of the gap can each be sampled exactly. The same setting lets a request be dropped mid-gap within a few cycles. It also makes the difference between counting from the output falling and counting from the command falling a matter of three cycles, which is easy to observe.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    typedef enum logic [0:0] {
        CH_TOP = 1'b0,
        CH_BOT = 1'b1
    } hb_chan_e;

    typedef struct packed {
        logic top;
        logic bot;
    } hb_pair_t;

    // Round a duration in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                                 longint unsigned dur_ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = clk_hz * dur_ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc < 64'd1) cyc = 64'd1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/hbdt_gap_timer.sv
module hbdt_gap_timer #(
    parameter int unsigned DEAD_CYC = 200,
    localparam int unsigned CNT_W = $clog2(DEAD_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic opp_gate,
    output logic expired
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEAD_CYC);

    logic [CNT_W-1:0] off_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cnt <= LIMIT;
        end else if (opp_gate) begin
            off_cnt <= '0;
        end else if (off_cnt != LIMIT) begin
            off_cnt <= off_cnt + CNT_W'(1);
        end
    end

    assign expired = (off_cnt == LIMIT);

    // R1: counter leaves reset in the expired state
    assert_reset_expired_R1: assert property (@(posedge clk)
        $fell(rst) |-> expired);

    // R5: the gap can only be over if the opposite gate was off last cycle
    assert_expired_after_off_R5: assert property (@(posedge clk) disable iff (rst)
        (expired && !$past(rst)) |-> $past(!opp_gate));

endmodule

// File: rtl/hbdt_gate_path.sv
module hbdt_gate_path (
    input  logic rst,
    input  logic bypass,
    input  logic cmd_self,
    input  logic cmd_opp,
    input  logic opp_expired,
    output logic gate
);
    logic allow_on;

    always_comb begin
        allow_on = bypass | (~cmd_opp & opp_expired);
        gate     = ~rst & cmd_self & allow_on;
    end

endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen #(
    parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
    parameter longint unsigned DEAD_NS     = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_bypass,
    input  logic cmd_top,
    input  logic cmd_bot,
    output logic gate_top,
    output logic gate_bot
);
    import hbdt_pkg::*;

    localparam int unsigned DEAD_CYC = ns_to_cycles(CLK_FREQ_HZ, DEAD_NS);

    hb_pair_t cmd;
    hb_pair_t gate;
    hb_pair_t opp_ok;

    assign cmd.top = cmd_top;
    assign cmd.bot = cmd_bot;

    logic [1:0] cmd_v;
    logic [1:0] gate_v;
    logic [1:0] ok_v;

    assign cmd_v[CH_TOP] = cmd.top;
    assign cmd_v[CH_BOT] = cmd.bot;

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        // Timer for channel ch watches the opposite channel's gate.
        hbdt_gap_timer #(.DEAD_CYC(DEAD_CYC)) timer_i (
            .clk      (clk),
            .rst      (rst),
            .opp_gate (gate_v[1-ch]),
            .expired  (ok_v[ch])
        );

        hbdt_gate_path path_i (
            .rst         (rst),
            .bypass      (cfg_bypass),
            .cmd_self    (cmd_v[ch]),
            .cmd_opp     (cmd_v[1-ch]),
            .opp_expired (ok_v[ch]),
            .gate        (gate_v[ch])
        );
    end

    assign gate.top   = gate_v[CH_TOP];
    assign gate.bot   = gate_v[CH_BOT];
    assign opp_ok.top = ok_v[CH_TOP];
    assign opp_ok.bot = ok_v[CH_BOT];

    assign gate_top = gate.top;
    assign gate_bot = gate.bot;

    // R2: never both on while interlock is active
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_bypass |-> !(gate_top && gate_bot));

    // R3: simultaneous commands keep both switches off
    assert_both_cmd_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && cmd_top && cmd_bot) |-> (!gate_top && !gate_bot));

    // R4: turn-off is not delayed
    assert_off_passes_R4: assert property (@(posedge clk) disable iff (rst)
        (!cmd_top |-> !gate_top) and (!cmd_bot |-> !gate_bot));

    // R5: a rising gate needs the partner gate to have been off
    assert_on_after_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && $rose(gate_top)) |-> (opp_ok.top && $past(!gate_bot)));

    // R9: bypass mirrors the commands
    assert_bypass_mirror_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_bypass |-> (gate_top == cmd_top && gate_bot == cmd_bot));

endmodule

// File: tb/hb_deadtime_gen_tb_top.sv
module hb_deadtime_gen_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_bypass = 1'b0;
    logic cmd_top = 1'b0;
    logic cmd_bot = 1'b0;
    logic gate_top;
    logic gate_bot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // CLK_FREQ_HZ 125 MHz, 80 ns -> 10 cycle gap (R10)
    hb_deadtime_gen #(.CLK_FREQ_HZ(125_000_000), .DEAD_NS(80)) dut_i (
        .clk(clk), .rst(rst), .cfg_bypass(cfg_bypass),
        .cmd_top(cmd_top), .cmd_bot(cmd_bot),
        .gate_top(gate_top), .gate_bot(gate_bot)
    );

    // Entry: {req[3:0], cfg, cmd_top, cmd_bot, exp_top, exp_bot, hold[7:0]}
    localparam int NV = 19;
    localparam logic [16:0] VEC [NV] = '{
        {4'd1,  1'b0,1'b1,1'b0, 1'b1,1'b0, 8'd5 },  // R1 lone command passes
        {4'd4,  1'b0,1'b0,1'b0, 1'b0,1'b0, 8'd3 },  // R4 off at once
        {4'd7,  1'b0,1'b0,1'b1, 1'b0,1'b0, 8'd6 },  // R7 held during gap
        {4'd5,  1'b0,1'b0,1'b1, 1'b0,1'b0, 8'd1 },  // R5 last blocked cycle
        {4'd5,  1'b0,1'b0,1'b1, 1'b0,1'b1, 8'd12},  // R5 first allowed cycle
        {4'd4,  1'b0,1'b0,1'b0, 1'b0,1'b0, 8'd4 },  // R4
        {4'd7,  1'b0,1'b1,1'b0, 1'b0,1'b0, 8'd2 },  // R7 request in gap
        {4'd7,  1'b0,1'b0,1'b0, 1'b0,1'b0, 8'd20},  // R7 request dropped
        {4'd6,  1'b0,1'b1,1'b0, 1'b1,1'b0, 8'd3 },  // R6 long gap passes
        {4'd4,  1'b0,1'b0,1'b0, 1'b0,1'b0, 8'd12},  // R4
        {4'd6,  1'b0,1'b0,1'b1, 1'b0,1'b1, 8'd3 },  // R6
        {4'd3,  1'b0,1'b1,1'b1, 1'b0,1'b0, 8'd3 },  // R3 both high
        {4'd8,  1'b0,1'b1,1'b0, 1'b0,1'b0, 8'd6 },  // R8 gap from output off
        {4'd8,  1'b0,1'b1,1'b0, 1'b0,1'b0, 8'd1 },  // R8
        {4'd8,  1'b0,1'b1,1'b0, 1'b1,1'b0, 8'd2 },  // R8 on at 10 after output off
        {4'd9,  1'b1,1'b1,1'b1, 1'b1,1'b1, 8'd2 },  // R9 bypass both
        {4'd9,  1'b1,1'b0,1'b1, 1'b0,1'b1, 8'd2 },  // R9
        {4'd9,  1'b1,1'b1,1'b0, 1'b1,1'b0, 8'd2 },  // R9 no gap
        {4'd4,  1'b0,1'b0,1'b0, 1'b0,1'b0, 8'd20}   // R4
    };

    task automatic check(input int req, input logic et, input logic eb);
        checks++;
        if (gate_top !== et || gate_bot !== eb) begin
            errors++;
            $display("FAIL R%0d: gate_top/gate_bot = %b%b, expected %b%b",
                     req, gate_top, gate_bot, et, eb);
        end
    endtask

    // R2 checked in every cycle of interlock mode
    always @(negedge clk) begin
        if (!rst && !cfg_bypass && !done) begin
            #2;
            checks++;
            if (gate_top && gate_bot) begin
                errors++;
                $display("FAIL R2: both gates on, actual 11 expected not 11");
            end
        end
    end

    initial begin
        @(negedge clk);
        cmd_top = 1'b1;
        #1 check(1, 1'b0, 1'b0);            // R1 outputs off in reset
        repeat (3) @(negedge clk);
        cmd_top = 1'b0;
        rst = 1'b0;
        #1 check(1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_bypass = VEC[i][12];
            cmd_top    = VEC[i][11];
            cmd_bot    = VEC[i][10];
            #1 check(int'(VEC[i][16:13]), VEC[i][9], VEC[i][8]);
            repeat (int'(VEC[i][7:0]) - 1) @(negedge clk);
        end

        // R1 directed: reset mid-gap re-expires counters
        @(negedge clk);
        cmd_bot = 1'b1;
        repeat (15) @(negedge clk);
        #1 check(1, 1'b0, 1'b1);
        @(negedge clk);
        cmd_bot = 1'b0;
        rst = 1'b1;
        #1 check(1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        cmd_top = 1'b1;
        #1 check(1, 1'b1, 1'b0);            // expired right after reset
        @(negedge clk);
        cmd_top = 1'b0;
        #1 check(4, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule